// File: doc/BRIEF.md
# One-Wire ROM Identity Reader

This sequencer fetches the 64-bit ROM identity of the single device on a one-wire bus. It does not time the bus itself. It sits above a bit-level master and hands that master one command at a time: a bus reset with presence sampling, a write slot, or a read slot. Each command is held until the master acknowledges it.

After a `start` pulse the reader issues one reset and records whether a presence pulse came back. It then writes the read-ROM command byte and collects eight bytes. It splits those bytes into a family code, a 48-bit serial number and a check byte. It recomputes the one-wire CRC-8 over the first seven bytes and compares it with the check byte. The results are loaded together with a single-cycle `done` pulse and are held until the next run completes.

A missing device does not stop the run. The sequence still finishes, so every accepted start ends in exactly one `done`.

Top module: `owid_reader`

## Requirements
- R1: After reset, `done`, `cmd_valid`, `crc_err`, `no_dev`, `family`, `rom_id` and `crc_byte` are all zero.
- R2: After `start`, the first command offered is a bus reset, `cmd_op` = 2'b00.
- R3: After the reset is acknowledged, eight write slots follow, each with `cmd_op` = 2'b01. They carry the bits of 0x33 on `cmd_bit`, least significant bit first.
- R4: After the write slots, exactly 64 read slots follow, each with `cmd_op` = 2'b10. No further command is offered before the next `start`.
- R5: `family` is the first byte read. Within every byte, the first bit read lands in bit 0.
- R6: `rom_id` holds the next six bytes. The byte read second lands in `rom_id[7:0]` and the byte read seventh lands in `rom_id[47:40]`.
- R7: `crc_byte` is the eighth byte read.
- R8: `crc_err` is 1 exactly when the CRC-8 of the first seven bytes differs from `crc_byte`. The CRC uses polynomial x^8+x^5+x^4+1, processes bits LSB first and starts from zero.
- R9: `no_dev` is the value of `ack_bit` on the reset acknowledge, where 1 means no presence pulse. With no device present the sequence still runs to `done`.
- R10: `done` is high for exactly one cycle per accepted start. A `start` that arrives while a run is in progress is ignored.
- R11: While `cmd_valid` is high and no acknowledge has arrived, `cmd_op` and `cmd_bit` hold their values.
- R12: The result outputs change only in the cycle in which `done` is high, and otherwise hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a read of the identity |
| cmd_valid | output | 1 | A command is offered to the bit master |
| cmd_op | output | 2 | 00 reset, 01 write slot, 10 read slot |
| cmd_bit | output | 1 | Bit to send in a write slot |
| cmd_ack | input | 1 | One-cycle acknowledge from the bit master |
| ack_bit | input | 1 | Sampled bus level that comes with the acknowledge |
| family | output | 8 | Family code byte |
| rom_id | output | 48 | Serial number, first received byte lowest |
| crc_byte | output | 8 | Received check byte |
| crc_err | output | 1 | Check byte does not match the computed CRC |
| no_dev | output | 1 | No presence pulse was seen |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the reader with its defaults: command byte 0x33 and an eight-byte frame. That gives 64 read slots, a CRC register that runs over 56 data bits, and field boundaries at bits 8 and 56. This lets every byte position and the first and last bit of each field be observed. A bench-side bit master answers each command after a random delay of zero to three cycles, and it checks that commands arrive in the required order. Directed frames cover a valid identity, a corrupted check byte, an all-zero frame, an absent device, and a start that arrives in the middle of a run. Seeded random frames then mix valid and corrupted check bytes.

// File: rtl/owid_reader.sv
module owid_reader #(
  parameter logic [7:0] CMD_BYTE  = 8'h33,
  parameter int         ROM_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       cmd_valid,
  output logic [1:0]                 cmd_op,
  output logic                       cmd_bit,
  input  logic                       cmd_ack,
  input  logic                       ack_bit,
  output logic [7:0]                 family,
  output logic [(ROM_BYTES-2)*8-1:0] rom_id,
  output logic [7:0]                 crc_byte,
  output logic                       crc_err,
  output logic                       no_dev,
  output logic                       done
);
  localparam int ROMW = ROM_BYTES * 8;
  localparam int IDW  = (ROM_BYTES - 2) * 8;
  localparam int CW   = $clog2(ROMW + 1);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_CMD, S_READ} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [ROMW-1:0] sh;
  logic [7:0]      crc;
  logic            absent;

  logic [ROMW-1:0] sh_next;
  logic [7:0]      crc_next;
  logic            fb;

  assign sh_next  = {ack_bit, sh[ROMW-1:1]};
  assign fb       = crc[0] ^ ack_bit;
  assign crc_next = (crc >> 1) ^ (fb ? 8'h8C : 8'h00);

  assign cmd_valid = (state != S_IDLE);
  assign cmd_op    = (state == S_RST) ? 2'b00 : (state == S_CMD) ? 2'b01 : 2'b10;
  assign cmd_bit   = (state == S_CMD) ? CMD_BYTE[cnt[2:0]] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      crc      <= '0;
      absent   <= 1'b0;
      family   <= '0;
      rom_id   <= '0;
      crc_byte <= '0;
      crc_err  <= 1'b0;
      no_dev   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RST;
          cnt   <= '0;
          crc   <= '0;
        end
        S_RST: if (cmd_ack) begin
          absent <= ack_bit;
          state  <= S_CMD;
          cnt    <= '0;
        end
        S_CMD: if (cmd_ack) begin
          if (cnt == CW'(7)) begin
            state <= S_READ;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READ: if (cmd_ack) begin
          sh  <= sh_next;
          crc <= crc_next;
          if (cnt == CW'(ROMW - 1)) begin
            state    <= S_IDLE;
            done     <= 1'b1;
            family   <= sh_next[7:0];
            rom_id   <= sh_next[IDW+7:8];
            crc_byte <= sh_next[ROMW-1:ROMW-8];
            crc_err  <= (crc_next != 8'h00);
            no_dev   <= absent;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owid_reader_chk.sv
module owid_reader_chk #(
  parameter int IDW = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic [1:0]     cmd_op,
  input logic           cmd_bit,
  input logic           cmd_ack,
  input logic [7:0]     family,
  input logic [IDW-1:0] rom_id,
  input logic [7:0]     crc_byte,
  input logic           crc_err,
  input logic           no_dev,
  input logic           done
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  p_legal_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'b11));

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bit)));

  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(family) && $stable(rom_id) && $stable(crc_byte)
               && $stable(crc_err) && $stable(no_dev)));
endmodule

bind owid_reader owid_reader_chk #(.IDW(IDW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bit(cmd_bit), .cmd_ack(cmd_ack), .family(family), .rom_id(rom_id),
  .crc_byte(crc_byte), .crc_err(crc_err), .no_dev(no_dev), .done(done)
);

// File: tb/test_owid_reader.sv
module test_owid_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_bit;
  logic        cmd_ack = 1'b0;
  logic        ack_bit = 1'b0;
  logic [7:0]  family;
  logic [47:0] rom_id;
  logic [7:0]  crc_byte;
  logic        crc_err;
  logic        no_dev;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] rom_m = '0;
  logic        nodev_m = 1'b0;
  int pos = 0;
  int err2 = 0, err3 = 0, err4 = 0;
  int dly = 0;

  localparam logic [7:0] CMD = 8'h33;

  always #10 clk = ~clk;

  owid_reader i_owid_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_ack(cmd_ack), .ack_bit(ack_bit),
    .family(family), .rom_id(rom_id), .crc_byte(crc_byte), .crc_err(crc_err),
    .no_dev(no_dev), .done(done)
  );

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f = c[0] ^ d[i];
      c = (c >> 1) ^ (f ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit-master model with random acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_ack) begin
        cmd_ack = 1'b0;
      end else if (cmd_valid) begin
        if (dly > 0) begin
          dly--;
        end else begin
          if (pos == 0) begin
            if (cmd_op != 2'b00) err2++;
            ack_bit = nodev_m;
          end else if (pos <= 8) begin
            if (cmd_op != 2'b01 || cmd_bit != CMD[pos-1]) err3++;
            ack_bit = 1'b1;
          end else if (pos <= 72) begin
            if (cmd_op != 2'b10) err4++;
            ack_bit = nodev_m ? 1'b1 : rom_m[pos-9];
          end else begin
            err4++;
          end
          pos++;
          cmd_ack = 1'b1;
          dly = int'($urandom_range(3, 0));
        end
      end
    end
  end

  task automatic run_one(input logic [63:0] img, input logic nd, input bit poke);
    logic [63:0] v;
    int ndone;
    int t;
    logic [7:0] f0, c0;
    logic [47:0] id0;
    logic e0, n0;
    rom_m = img; nodev_m = nd; pos = 0; err2 = 0; err3 = 0; err4 = 0;
    v = nd ? {64{1'b1}} : img;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    ndone = 0; t = 0;
    while (ndone == 0 && t < 3000) begin
      @(negedge clk);
      t++;
      start = (poke && t == 20);
      if (done) ndone++;
    end
    start = 1'b0;
    chk("R10 done seen", 64'(ndone), 64'd1);
    chk("R5 family", 64'(family), 64'(v[7:0]));
    chk("R6 rom_id", 64'(rom_id), 64'(v[55:8]));
    chk("R7 crc_byte", 64'(crc_byte), 64'(v[63:56]));
    chk("R8 crc_err", 64'(crc_err), 64'(crc8(v[55:0]) != v[63:56]));
    chk("R9 no_dev", 64'(no_dev), 64'(nd));
    f0 = family; id0 = rom_id; c0 = crc_byte; e0 = crc_err; n0 = no_dev;
    for (int k = 0; k < 6 + int'($urandom_range(8, 0)); k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R10 single done", 64'(ndone), 64'd1);
    chk("R2 reset first", 64'(err2), 64'd0);
    chk("R3 command bits", 64'(err3), 64'd0);
    chk("R4 read slots", 64'(err4), 64'd0);
    chk("R4 command count", 64'(pos), 64'd73);
    chk("R12 outputs held", {f0, c0, id0}, {family, crc_byte, rom_id});
    chk("R12 flags held", {e0, n0}, {crc_err, no_dev});
  endtask

  function automatic logic [63:0] good_rom(input logic [47:0] id);
    logic [55:0] low = {id, 8'h01};
    return {crc8(low), low};
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] img;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {family, crc_byte, rom_id}, 64'd0);
    chk("R1 reset flags", {60'd0, done, cmd_valid, crc_err, no_dev}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_one(good_rom(48'h123456789ABC), 1'b0, 1'b0);
    chk("R8 valid frame clean", 64'(crc_err), 64'd0);
    img = good_rom(48'hA5A5_0F0F_FF00);
    img[63:56] = img[63:56] ^ 8'h40;
    run_one(img, 1'b0, 1'b0);
    chk("R8 corrupted frame flagged", 64'(crc_err), 64'd1);
    run_one(64'd0, 1'b0, 1'b0);
    run_one(good_rom(48'h000000000001), 1'b1, 1'b0);
    run_one(good_rom(48'h800000000000), 1'b0, 1'b1);
    for (int n = 0; n < 20; n++) begin
      img = good_rom({$urandom, 16'($urandom)});
      if ($urandom_range(1, 0) == 1) img = img ^ (64'd1 << $urandom_range(63, 0));
      run_one(img, ($urandom_range(7, 0) == 0), ($urandom_range(3, 0) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule